// File: doc/BRIEF.md
# Variable-Length SPI Shift Engine

This block is the serial core of an SPI master. It takes transmit entries from a FIFO through a valid/ready port. Each entry carries its own bit count (1 to 24), up to 24 data bits aligned to the top of the word, and a hold flag. The engine drives SCK from a programmable divider and supports either idle polarity. The edge that changes MOSI and the edge that samples MISO are chosen independently. Data goes out most significant bit first. The bits received for each entry are presented on an RX port as one word with a single-cycle valid pulse. The engine drives one active-low chip select.

After each entry the engine leaves two idle SCK periods. An entry marked as held keeps chip select low into the following entry. An entry that is not held releases chip select one SCK period after its last bit. A busy flag and a live count of sampled bits are brought out for the surrounding logic.

Top module: `spi_vlen_engine`

## Requirements
- R1: SCK toggles once every `cfg_div`+1 system clocks while an entry is shifting, so one SCK period is 2*(`cfg_div`+1) clocks; `cfg_div`=0xFFF gives the slowest rate (8192 clocks per period).
- R2: While `cs_n` is high, `sck` sits at the level of `cfg_cpol` (0 = idle low, 1 = idle high) and does not toggle.
- R3: MOSI sends `tx_data[23]` first, then the bits below it, one bit per SCK period. MOSI changes on SCK rising edges when `cfg_launch_rise`=1 and on falling edges when it is 0. The first bit is already on MOSI before the first edge. MISO is sampled on rising edges when `cfg_sample_rise`=1 and on falling edges when it is 0. The two edge settings must differ.
- R4: An accepted entry with `tx_len`=L (1..24) produces exactly L SCK pulses, which is 2L edges.
- R5: After the last edge of an entry, `rx_valid` is high for exactly one cycle. At that time `rx_data` holds the L received bits, first bit most significant, with the last bit in bit 0 and all higher bits zero. For L=24, the first byte received is in bits 23:16.
- R6: `tx_ready` is high in idle. On acceptance `cs_n` goes low on the accepting clock edge, and the first SCK edge follows `cfg_div`+1 clocks later.
- R7: For an entry with `tx_hold`=0, `cs_n` rises 2*(`cfg_div`+1) clocks after that entry's last SCK edge.
- R8: After each entry the engine keeps two idle SCK periods. If the next entry is already waiting, its first SCK edge comes 5*(`cfg_div`+1) clocks after the previous entry's last edge.
- R9: For an entry with `tx_hold`=1, `cs_n` stays low through the idle gap and into the next entry. For an entry with `tx_hold`=0, `cs_n` goes high between the two entries.
- R10: `busy` rises with the first SCK edge of a transfer and falls when `cs_n` is released. It is never high while `cs_n` is high.
- R11: `bit_cnt` clears to 0 when an entry is accepted and counts each MISO sample. It reads L when `rx_valid` is high, and it never exceeds 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 12 | Divider setting; half SCK period is cfg_div+1 clocks |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_launch_rise | input | 1 | 1: MOSI changes on rising SCK, 0: on falling |
| cfg_sample_rise | input | 1 | 1: MISO sampled on rising SCK, 0: on falling |
| tx_valid | input | 1 | Transmit entry available |
| tx_ready | output | 1 | Engine takes the entry this cycle |
| tx_data | input | 24 | Entry data, first bit in bit 23 |
| tx_len | input | 6 | Entry bit count, 1..24 |
| tx_hold | input | 1 | Keep chip select low after this entry |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a finished entry |
| rx_data | output | 24 | Received bits, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer in progress |
| bit_cnt | output | 6 | Bits sampled in the current entry |

## Verification
The checks assume that every accepted entry has a length from 1 to 24. They also assume that the launch edge and the sample edge are set to opposite directions. The configuration inputs change only while `cs_n` is high and the engine is idle. The bench changes configuration only after a transfer has fully drained. It drives only legal lengths, including the extremes 1 and 24. It loops MOSI back to MISO, either straight or inverted, so that each edge setting it uses has a known expected received word.

// File: rtl/spi_vlen_pkg.sv
package spi_vlen_pkg;
  localparam int DATA_W_DEF = 24;
  localparam int LEN_W_DEF  = 6;
  localparam int DIV_W_DEF  = 12;
  localparam int GAP_TICKS_DEF = 4;   // two idle SCK periods, in half periods
  localparam int CS_OFF_TICK_DEF = 2; // one SCK period after last edge

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_HWAIT = 2'd3
  } eng_state_t;

  // Index of the last SCK edge of an entry of len bits (2*len-1).
  function automatic logic [LEN_W_DEF:0] final_edge_idx(input logic [LEN_W_DEF-1:0] len);
    return {len, 1'b0} - {{LEN_W_DEF{1'b0}}, 1'b1};
  endfunction

  // Direction of the next edge: rising when SCK is currently low.
  function automatic logic next_edge_rising(input logic sck_now);
    return ~sck_now;
  endfunction
endpackage

// File: rtl/spi_vlen_divider.sv
module spi_vlen_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] half_cnt;

  assign tick = run && (half_cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
    end else if (restart || !run || tick) begin
      half_cnt <= '0;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_vlen_shifter.sv
module spi_vlen_shifter #(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              launch,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic [LEN_W-1:0]  bit_cnt
);
  logic [DATA_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      tx_sh   <= {load_data[DATA_W-2:0], 1'b0};
      mosi    <= load_data[DATA_W-1];
      rx_word <= '0;
      bit_cnt <= '0;
    end else begin
      if (launch) begin
        mosi  <= tx_sh[DATA_W-1];
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
      if (sample) begin
        rx_word <= {rx_word[DATA_W-2:0], miso};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_vlen_engine.sv
module spi_vlen_engine
  import spi_vlen_pkg::*;
#(
  parameter int DATA_W      = DATA_W_DEF,
  parameter int LEN_W       = LEN_W_DEF,
  parameter int DIV_W       = DIV_W_DEF,
  parameter int GAP_TICKS   = GAP_TICKS_DEF,
  parameter int CS_OFF_TICK = CS_OFF_TICK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpol,
  input  logic              cfg_launch_rise,
  input  logic              cfg_sample_rise,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              tx_hold,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              busy,
  output logic [LEN_W-1:0]  bit_cnt
);
  localparam int EDGE_W = LEN_W + 1;
  localparam int GAP_W  = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  eng_state_t       state;
  logic             phase;
  logic [EDGE_W-1:0] edge_cnt;
  logic [LEN_W-1:0] len_q;
  logic             hold_q;
  logic [GAP_W-1:0] gap_cnt;

  // Named internal events
  logic tick, accept, sck_edge, edge_rising, first_edge, last_edge;
  logic launch_now, sample_now, gap_done, cs_off_now, div_run;

  assign sck         = phase ^ cfg_cpol;
  assign div_run     = (state == ST_SHIFT) || (state == ST_GAP);
  assign sck_edge    = (state == ST_SHIFT) && tick;
  assign edge_rising = next_edge_rising(sck);
  assign first_edge  = (edge_cnt == '0);
  assign last_edge   = (edge_cnt == final_edge_idx(len_q));
  assign launch_now  = sck_edge && (edge_rising == cfg_launch_rise) && !first_edge && !last_edge;
  assign sample_now  = sck_edge && (edge_rising == cfg_sample_rise);
  assign gap_done    = (state == ST_GAP) && tick && (gap_cnt == GAP_W'(GAP_TICKS - 1));
  assign cs_off_now  = (state == ST_GAP) && tick && !hold_q &&
                       (gap_cnt == GAP_W'(CS_OFF_TICK - 1));
  assign tx_ready    = (state == ST_IDLE) || (state == ST_HWAIT) || gap_done;
  assign accept      = tx_valid && tx_ready;

  spi_vlen_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (div_run),
    .restart (accept),
    .div     (cfg_div),
    .tick    (tick)
  );

  spi_vlen_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (tx_data),
    .launch    (launch_now),
    .sample    (sample_now),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data),
    .bit_cnt   (bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      edge_cnt <= '0;
      len_q    <= '0;
      hold_q   <= 1'b0;
      gap_cnt  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (accept) begin
        state    <= ST_SHIFT;
        cs_n     <= 1'b0;
        len_q    <= tx_len;
        hold_q   <= tx_hold;
        edge_cnt <= '0;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (tick) begin
              phase    <= ~phase;
              busy     <= 1'b1;
              edge_cnt <= edge_cnt + 1'b1;
              if (last_edge) begin
                state    <= ST_GAP;
                gap_cnt  <= '0;
                rx_valid <= 1'b1;
              end
            end
          end
          ST_GAP: begin
            if (tick) begin
              gap_cnt <= gap_cnt + 1'b1;
              if (cs_off_now) begin
                cs_n <= 1'b1;
                busy <= 1'b0;
              end
              if (gap_done) begin
                state <= hold_q ? ST_HWAIT : ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_vlen_engine_chk.sv
module spi_vlen_engine_chk #(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cpol,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [LEN_W-1:0] tx_len,
  input logic             rx_valid,
  input logic             sck,
  input logic             cs_n,
  input logic             busy,
  input logic [LEN_W-1:0] bit_cnt
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cfg_cpol)); // R2

  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(cfg_cpol)) |-> $stable(sck)); // R2

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> ((tx_len != '0) && (tx_len <= LEN_W'(DATA_W)))); // R4

  AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !cs_n); // R6

  AST_RX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_n); // R5

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5

  AST_BUSY_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !busy); // R10

  AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LEN_W'(DATA_W)); // R11
endmodule

bind spi_vlen_engine spi_vlen_engine_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_cpol (cfg_cpol),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_len   (tx_len),
  .rx_valid (rx_valid),
  .sck      (sck),
  .cs_n     (cs_n),
  .busy     (busy),
  .bit_cnt  (bit_cnt)
);

// File: tb/spi_vlen_engine_bench.sv
`timescale 1ns/1ps
module spi_vlen_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_div = 12'd1;
  logic        cfg_cpol = 1'b0, cfg_launch_rise = 1'b0, cfg_sample_rise = 1'b1;
  logic        tx_valid = 1'b0, tx_hold = 1'b0;
  logic        tx_ready;
  logic [23:0] tx_data = '0;
  logic [5:0]  tx_len = 6'd1;
  logic        rx_valid;
  logic [23:0] rx_data;
  logic        sck, mosi, miso, cs_n, busy;
  logic [5:0]  bit_cnt;
  logic        loop_inv = 1'b0;

  assign miso = mosi ^ loop_inv;

  always #10 clk = ~clk; // 50 MHz

  spi_vlen_engine u_spi_vlen_engine (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
    .cfg_launch_rise(cfg_launch_rise), .cfg_sample_rise(cfg_sample_rise),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_len(tx_len),
    .tx_hold(tx_hold), .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy), .bit_cnt(bit_cnt)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor state
  logic        mon_clr = 1'b0;
  int          edge_cyc [0:127];
  int          nedge = 0, nrx = 0, cs_rise_cnt = 0, cs_rise_cyc = 0, busy_err = 0;
  logic [31:0] mon_word = '0;
  logic [23:0] rx_cap [0:3];
  logic [5:0]  bc_cap [0:3];
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  int          acc_cyc = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      nedge = 0; nrx = 0; cs_rise_cnt = 0; busy_err = 0; mon_word = '0;
    end else if (rst_n) begin
      if ((sck !== prev_sck) && !cs_n) begin
        if (nedge < 128) edge_cyc[nedge] = cyc;
        nedge++;
        if (busy !== 1'b1) busy_err++;
        if ((sck == 1'b1) == cfg_sample_rise) mon_word = {mon_word[30:0], mosi};
      end
      if (cs_n && !prev_cs) begin
        cs_rise_cnt++;
        cs_rise_cyc = cyc;
      end
      if (cs_n && busy) busy_err++;
      if (rx_valid && nrx < 4) begin
        rx_cap[nrx] = rx_data;
        bc_cap[nrx] = bit_cnt;
        nrx++;
      end
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [23:0] d, input logic [5:0] l, input logic h);
    tx_data = d; tx_len = l; tx_hold = h; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done(input int half);
    while (!cs_n) @(negedge clk);
    repeat (4 * half + 4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [11:0] d, input logic pol, input logic lr,
                         input logic sr, input logic inv);
    @(negedge clk);
    cfg_div = d; cfg_cpol = pol; cfg_launch_rise = lr; cfg_sample_rise = sr; loop_inv = inv;
    @(negedge clk);
  endtask

  function automatic logic [31:0] bits_of(input logic [23:0] d, input int l);
    return 32'(d) >> (24 - l);
  endfunction

  function automatic logic [31:0] mask_of(input int l);
    return (32'd1 << l) - 32'd1;
  endfunction

  task automatic t_reset();
    chk("R6 cs_n after reset", 32'(cs_n), 32'd1);
    chk("R2 sck idle after reset", 32'(sck), 32'd0);
    chk("R10 busy after reset", 32'(busy), 32'd0);
    chk("R6 tx_ready after reset", 32'(tx_ready), 32'd1);
    chk("R5 rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R11 bit_cnt after reset", 32'(bit_cnt), 32'd0);
  endtask

  task automatic t_single(input string name, input logic [11:0] d, input logic pol,
                          input logic lr, input logic sr, input logic inv,
                          input logic [23:0] data, input int l);
    int half;
    logic [31:0] exp_bits, exp_rx;
    half = int'(d) + 1;
    set_cfg(d, pol, lr, sr, inv);
    chk({"R2 idle level ", name}, 32'(sck), 32'(pol));
    clear_mon();
    push(data, 6'(l), 1'b0);
    if (half >= 2) begin
      chk({"R10 busy before first edge ", name}, 32'(busy), 32'd0);
      chk({"R6 cs low after accept ", name}, 32'(cs_n), 32'd0);
    end
    wait_done(half);
    exp_bits = bits_of(data, l);
    exp_rx   = inv ? (~exp_bits & mask_of(l)) : exp_bits;
    chk({"R4 edge count ", name}, 32'(nedge), 32'(2 * l));
    chk({"R6 setup to first edge ", name}, 32'(edge_cyc[0] - acc_cyc), 32'(half));
    if (l >= 2)
      chk({"R1 sck period ", name}, 32'(edge_cyc[2] - edge_cyc[0]), 32'(2 * half));
    chk({"R1 frame span ", name}, 32'(edge_cyc[2*l-1] - edge_cyc[0]), 32'((2 * l - 1) * half));
    chk({"R3 mosi bits ", name}, mon_word & mask_of(l), exp_bits);
    chk({"R5 rx pulses ", name}, 32'(nrx), 32'd1);
    chk({"R5 rx word ", name}, 32'(rx_cap[0]), exp_rx);
    chk({"R11 bit count ", name}, 32'(bc_cap[0]), 32'(l));
    chk({"R7 cs release ", name}, 32'(cs_rise_cyc - edge_cyc[2*l-1]), 32'(2 * half));
    chk({"R10 busy window ", name}, 32'(busy_err), 32'd0);
    chk({"R2 idle level after ", name}, 32'(sck), 32'(pol));
  endtask

  task automatic t_pair(input string name, input logic h);
    logic [23:0] a, b;
    int half;
    a = 24'hC3_5A_96; b = 24'h6D_00_00;
    half = 2;
    set_cfg(12'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    clear_mon();
    push(a, 6'd16, h);
    push(b, 6'd8, 1'b0);
    wait_done(half);
    chk({"R4 pair edges ", name}, 32'(nedge), 32'd48);
    chk({"R8 idle gap ", name}, 32'(edge_cyc[32] - edge_cyc[31]), 32'(5 * half));
    chk({"R9 cs releases ", name}, 32'(cs_rise_cnt), h ? 32'd1 : 32'd2);
    chk({"R3 pair mosi ", name}, mon_word & 32'hFF_FFFF, {8'h00, a[23:8], b[23:16]});
    chk({"R5 pair rx count ", name}, 32'(nrx), 32'd2);
    chk({"R5 first rx ", name}, 32'(rx_cap[0]), 32'(a[23:8]));
    chk({"R5 second rx ", name}, 32'(rx_cap[1]), 32'(b[23:16]));
    chk({"R11 pair counts ", name}, {bc_cap[0], bc_cap[1]}, {6'd16, 6'd8});
    chk({"R7 final release ", name}, 32'(cs_rise_cyc - edge_cyc[47]), 32'(2 * half));
    chk({"R10 pair busy ", name}, 32'(busy_err), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single("mode0 len24", 12'd1, 1'b0, 1'b0, 1'b1, 1'b0, 24'hA5_3C_E1, 24);
    t_single("pol1 trailing launch len8", 12'd0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h9B_00_00, 8);
    t_single("leading launch len13 inverted", 12'd3, 1'b0, 1'b1, 1'b0, 1'b1, 24'h5E_71_00, 13);
    t_single("pol1 leading launch len1", 12'd2, 1'b1, 1'b0, 1'b1, 1'b0, 24'h80_00_00, 1);
    t_single("slowest divider len2", 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0, 24'h40_00_00, 2);
    t_pair("held", 1'b1);
    t_pair("released", 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule